// File: doc/BRIEF.md
# LIN Master Header Transmitter

This block drives the header of a LIN frame onto a single-wire serial line. When the host writes an identifier byte, the block sends a long dominant break, a one-bit recessive delimiter, a sync character and then the identifier character. Every bit lasts from one pulse of an external bit-tick enable to the next. The baud-rate divider is not part of the block: the host supplies the one-cycle `bit_tick` pulse at the bit rate.

The host sees a one-entry holding register and a ready flag. A write is taken only while `tx_ready` is high, and `tx_ready` then drops. The flag rises again when the held identifier moves into the character serializer at the start of the identifier character. A second identifier written while the first identifier character is still on the line is therefore held. Its header follows the first one without a gap. A write made while `tx_ready` is low is dropped.

With `auto_par` high at the time of the write, the two upper identifier bits are replaced by computed protection bits. With `auto_par` low, the byte is sent exactly as written.

Top module: `lin_hdr_tx`

## Requirements
- R1: After reset, and whenever no header is being sent, `txd` is 1 and `tx_ready` is 1.
- R2: A write (`id_wr` high while `tx_ready` is 1) drives `tx_ready` to 0 in the next cycle. The first break bit begins at the first `bit_tick` edge that comes after the accepting edge.
- R3: The break is exactly BREAK_BITS (default 13) consecutive bit times of 0.
- R4: The break is followed by exactly DELIM_BITS (default 1) bit time of 1.
- R5: The sync character follows the delimiter. It is a start bit 0, then the data bits of SYNC_CHAR (default 0x55) LSB first, then a stop bit 1.
- R6: The identifier character follows the sync character, framed the same way (start 0, 8 bits LSB first, stop 1). With `auto_par` 0 it carries the written byte unchanged.
- R7: With `auto_par` 1 at the write, bits 5..0 of the identifier come from the written byte. Bit 6 is ID0^ID1^ID2^ID4 and bit 7 is NOT(ID1^ID3^ID4^ID5).
- R8: `tx_ready` returns to 1 in the cycle after the bit tick that starts the identifier character's start bit, and at no other time.
- R9: A write while `tx_ready` is 0 is ignored. The header in progress is unchanged and no extra header follows.
- R10: A write accepted while an identifier character is being sent is held. Its break starts at the bit tick that ends the current stop bit, with no idle bit in between.
- R11: `txd` changes only in the cycle after a `bit_tick` edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_tick | input | 1 | One-cycle enable marking each bit boundary |
| id_wr | input | 1 | Identifier write strobe |
| id_data | input | 8 | Identifier byte written with `id_wr` |
| auto_par | input | 1 | 1: compute the two upper identifier bits; 0: send the byte as written |
| tx_ready | output | 1 | 1 when a new identifier can be written |
| txd | output | 1 | Serial line output, idles at 1 |

## Verification
The bench builds the block with its default parameters: a 13-bit break, a one-bit delimiter and a 0x55 sync character. It pulses `bit_tick` every fourth clock, so a header of 34 bit times takes 136 cycles. At that rate a write can land mid-bit, and back-to-back headers, writes that fall during the break or the sync character, and queued writes during the identifier character all finish in short runs. The identifier values are chosen so that the runs of zeros in a character come near the break-length threshold the checker relies on.

// File: rtl/lin_hdr_pkg.sv
package lin_hdr_pkg;

  localparam int CHAR_BITS  = 8;
  localparam int FRAME_BITS = CHAR_BITS + 2;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_BREAK = 2'd1,
    PH_DELIM = 2'd2,
    PH_CHAR  = 2'd3
  } phase_t;

  // Protected identifier: two check bits over the 6-bit identifier.
  function automatic logic [7:0] lin_protect(input logic [5:0] ident);
    logic even_bit;
    logic odd_bit;
    even_bit = ident[0] ^ ident[1] ^ ident[2] ^ ident[4];
    odd_bit  = ~(ident[1] ^ ident[3] ^ ident[4] ^ ident[5]);
    return {odd_bit, even_bit, ident};
  endfunction

  // Character frame, bit 0 goes out first: start, data LSB first, stop.
  function automatic logic [FRAME_BITS-1:0] char_frame(input logic [CHAR_BITS-1:0] data);
    return {1'b1, data, 1'b0};
  endfunction

endpackage

// File: rtl/lin_hdr_hold.sv
module lin_hdr_hold
  import lin_hdr_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 id_wr,
  input  logic [CHAR_BITS-1:0] id_data,
  input  logic                 auto_par,
  input  logic                 take,
  output logic                 hold_valid,
  output logic [CHAR_BITS-1:0] hold_byte,
  output logic                 accept
);

  logic [CHAR_BITS-1:0] shaped;

  assign accept = id_wr & ~hold_valid;
  assign shaped = auto_par ? lin_protect(id_data[5:0]) : id_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_valid <= 1'b0;
      hold_byte  <= '0;
    end else if (accept) begin
      hold_valid <= 1'b1;
      hold_byte  <= shaped;
    end else if (take) begin
      hold_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/lin_hdr_shift.sv
module lin_hdr_shift
  import lin_hdr_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bit_tick,
  input  logic                 load,
  input  logic [CHAR_BITS-1:0] load_byte,
  output logic                 line_bit,
  output logic                 last_bit
);

  localparam int BW = $clog2(FRAME_BITS);
  localparam logic [BW-1:0] LAST_IDX = BW'(FRAME_BITS - 1);

  logic [FRAME_BITS-1:0] sreg;
  logic [BW-1:0]         bidx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg <= '1;
      bidx <= LAST_IDX;
    end else if (load) begin
      sreg <= char_frame(load_byte);
      bidx <= '0;
    end else if (bit_tick) begin
      sreg <= {1'b1, sreg[FRAME_BITS-1:1]};
      if (bidx != LAST_IDX) bidx <= bidx + 1'b1;
    end
  end

  assign line_bit = sreg[0];
  assign last_bit = (bidx == LAST_IDX);

endmodule

// File: rtl/lin_hdr_seq.sv
module lin_hdr_seq
  import lin_hdr_pkg::*;
#(
  parameter int BREAK_BITS = 13,
  parameter int DELIM_BITS = 1
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   bit_tick,
  input  logic   hold_valid,
  input  logic   char_last,
  output phase_t phase,
  output logic   load_sync,
  output logic   load_id
);

  localparam int LONGEST = (BREAK_BITS > DELIM_BITS) ? BREAK_BITS : DELIM_BITS;
  localparam int CW = $clog2(LONGEST + 1);
  localparam logic [CW-1:0] BRK_LAST = CW'(BREAK_BITS - 1);
  localparam logic [CW-1:0] DLM_LAST = CW'(DELIM_BITS - 1);

  logic [CW-1:0] cnt;
  logic          on_id;
  logic          char_end;

  assign char_end  = bit_tick & (phase == PH_CHAR) & char_last;
  assign load_sync = bit_tick & (phase == PH_DELIM) & (cnt == DLM_LAST);
  assign load_id   = char_end & ~on_id;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      on_id <= 1'b0;
    end else if (bit_tick) begin
      case (phase)
        PH_IDLE: begin
          if (hold_valid) begin
            phase <= PH_BREAK;
            cnt   <= '0;
          end
        end
        PH_BREAK: begin
          if (cnt == BRK_LAST) begin
            phase <= PH_DELIM;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_DELIM: begin
          if (cnt == DLM_LAST) begin
            phase <= PH_CHAR;
            on_id <= 1'b0;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_CHAR: begin
          if (char_last) begin
            if (!on_id) begin
              on_id <= 1'b1;
            end else if (hold_valid) begin
              phase <= PH_BREAK;
              cnt   <= '0;
            end else begin
              phase <= PH_IDLE;
            end
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/lin_hdr_tx.sv
module lin_hdr_tx
  import lin_hdr_pkg::*;
#(
  parameter int                   BREAK_BITS = 13,
  parameter int                   DELIM_BITS = 1,
  parameter logic [CHAR_BITS-1:0] SYNC_CHAR  = 8'h55
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bit_tick,
  input  logic                 id_wr,
  input  logic [CHAR_BITS-1:0] id_data,
  input  logic                 auto_par,
  output logic                 tx_ready,
  output logic                 txd
);

  phase_t               phase;
  logic                 hold_valid;
  logic [CHAR_BITS-1:0] hold_byte;
  logic                 accept;
  logic                 load_sync;
  logic                 handoff;
  logic                 char_load;
  logic [CHAR_BITS-1:0] char_byte;
  logic                 char_bit;
  logic                 char_last;

  lin_hdr_hold u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .id_wr      (id_wr),
    .id_data    (id_data),
    .auto_par   (auto_par),
    .take       (handoff),
    .hold_valid (hold_valid),
    .hold_byte  (hold_byte),
    .accept     (accept)
  );

  lin_hdr_seq #(
    .BREAK_BITS (BREAK_BITS),
    .DELIM_BITS (DELIM_BITS)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_tick   (bit_tick),
    .hold_valid (hold_valid),
    .char_last  (char_last),
    .phase      (phase),
    .load_sync  (load_sync),
    .load_id    (handoff)
  );

  assign char_load = load_sync | handoff;
  assign char_byte = handoff ? hold_byte : SYNC_CHAR;

  lin_hdr_shift u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_tick  (bit_tick),
    .load      (char_load),
    .load_byte (char_byte),
    .line_bit  (char_bit),
    .last_bit  (char_last)
  );

  assign tx_ready = ~hold_valid;

  always_comb begin
    case (phase)
      PH_BREAK: txd = 1'b0;
      PH_CHAR:  txd = char_bit;
      default:  txd = 1'b1;
    endcase
  end

endmodule

// File: rtl/lin_hdr_tx_chk.sv
module lin_hdr_tx_chk
  import lin_hdr_pkg::*;
#(
  parameter int BREAK_BITS = 13
) (
  input logic clk,
  input logic rst_n,
  input logic bit_tick,
  input logic id_wr,
  input logic tx_ready,
  input logic txd,
  input logic handoff
);

  localparam int ZW = $clog2(BREAK_BITS + 2) + 1;
  localparam logic [ZW-1:0] ZMAX = '1;

  // Length of the current run of dominant bits, counted at bit boundaries.
  logic [ZW-1:0] zrun;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) zrun <= '0;
    else if (bit_tick) begin
      if (txd) zrun <= '0;
      else if (zrun != ZMAX) zrun <= zrun + 1'b1;
    end
  end

  assert_break_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_tick && txd && zrun >= ZW'(FRAME_BITS)) |-> (zrun == ZW'(BREAK_BITS)));

  assert_take_clears_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (id_wr && tx_ready) |=> !tx_ready);

  assert_ready_falls_on_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_ready) |-> $past(id_wr));

  assert_ready_rises_on_handoff_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_ready) |-> $past(handoff));

  assert_line_moves_on_tick_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bit_tick) |-> $stable(txd));

endmodule

bind lin_hdr_tx lin_hdr_tx_chk #(.BREAK_BITS(BREAK_BITS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bit_tick (bit_tick),
  .id_wr    (id_wr),
  .tx_ready (tx_ready),
  .txd      (txd),
  .handoff  (handoff)
);

// File: tb/lin_hdr_tx_tb.sv
module lin_hdr_tx_tb;

  localparam int BRK  = 13;
  localparam int TDIV = 4;
  localparam int HL   = BRK + 1 + 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_tick = 1'b0;
  logic       id_wr = 1'b0;
  logic [7:0] id_data = 8'h00;
  logic       auto_par = 1'b0;
  logic       tx_ready;
  logic       txd;

  int checks = 0;
  int errors = 0;
  int tcnt = 0;
  int viol = 0;
  logic last_txd = 1'b1;
  bit bits[$];
  bit rdys[$];

  lin_hdr_tx u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_tick (bit_tick),
    .id_wr    (id_wr),
    .id_data  (id_data),
    .auto_par (auto_par),
    .tx_ready (tx_ready),
    .txd      (txd)
  );

  always #5 clk = ~clk;

  // Record the bit started by each tick edge, and watch for moves between ticks.
  always @(negedge clk) begin
    if (rst_n) begin
      if (bit_tick) begin
        bits.push_back(txd);
        rdys.push_back(tx_ready);
      end else if (txd !== last_txd) begin
        viol++;
      end
      last_txd = txd;
      tcnt = (tcnt + 1) % TDIV;
      bit_tick = (tcnt == 0);
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] prot(input logic [7:0] raw);
    logic p0, p1;
    p0 = ^(raw & 8'h17);
    p1 = ~^(raw & 8'h3A);
    return {p1, p0, raw[5:0]};
  endfunction

  function automatic logic [9:0] frame_at(input int i);
    logic [9:0] f;
    for (int j = 0; j < 10; j++) f[j] = (i + j < bits.size()) ? bits[i + j] : 1'bx;
    return f;
  endfunction

  task automatic wait_bits(input int n);
    int guard = 0;
    while (bits.size() < n && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    if (guard >= 20000) check(1'b0, "WD", "watchdog waiting for bits", bits.size(), n);
  endtask

  task automatic do_write(input logic [7:0] v, input bit ap, output int first_exp);
    @(posedge clk); #1;
    id_data = v; auto_par = ap; id_wr = 1'b1;
    @(posedge clk); #1;
    id_wr = 1'b0;
    first_exp = bits.size() + (bit_tick ? 1 : 0);
  endtask

  task automatic check_hdr(input int base, input logic [7:0] idb, input string rq);
    int z = 0;
    while (base + z < bits.size() && bits[base + z] == 1'b0) z++;
    check(z == BRK, "R3", "break length", z, BRK);
    check(bits[base + BRK] == 1'b1, "R4", "delimiter bit", bits[base + BRK], 1);
    check(frame_at(base + BRK + 1) == {1'b1, 8'h55, 1'b0}, "R5", "sync frame",
          frame_at(base + BRK + 1), {1'b1, 8'h55, 1'b0});
    check(frame_at(base + BRK + 11) == {1'b1, idb, 1'b0}, rq, "identifier frame",
          frame_at(base + BRK + 11), {1'b1, idb, 1'b0});
    check(rdys[base + BRK + 11] == 1'b1 && rdys[base + BRK + 10] == 1'b0, "R8",
          "ready at identifier handoff", {rdys[base + BRK + 10], rdys[base + BRK + 11]}, 2'b01);
  endtask

  task automatic expect_ones(input int from, input int n, input string rq);
    int bad = 0;
    for (int k = from; k < from + n; k++) if (bits[k] != 1'b1) bad++;
    check(bad == 0, rq, "line stays idle", bad, 0);
  endtask

  task automatic t_reset;
    int s;
    @(negedge clk);
    check(txd == 1'b1, "R1", "txd after reset", txd, 1);
    check(tx_ready == 1'b1, "R1", "tx_ready after reset", tx_ready, 1);
    s = bits.size();
    wait_bits(s + 8);
    expect_ones(s, 8, "R1");
  endtask

  task automatic t_single(input logic [7:0] v, input bit ap, input string rq);
    int fe;
    logic [7:0] sent;
    sent = ap ? prot(v) : v;
    do_write(v, ap, fe);
    check(tx_ready == 1'b0, "R2", "tx_ready after write", tx_ready, 0);
    wait_bits(fe + HL + 6);
    check(bits[fe] == 1'b0 && (fe == 0 || bits[fe - 1] == 1'b1), "R2",
          "break starts at first tick after write", bits[fe], 0);
    check_hdr(fe, sent, rq);
    expect_ones(fe + HL, 6, "R1");
    check(tx_ready == 1'b1, "R1", "tx_ready idle after header", tx_ready, 1);
  endtask

  task automatic t_ignore;
    int fe, dummy;
    do_write(8'h12, 1'b0, fe);
    wait_bits(fe + 5);
    do_write(8'h77, 1'b1, dummy);
    check(tx_ready == 1'b0, "R9", "write during break not taken", tx_ready, 0);
    wait_bits(fe + BRK + 4);
    do_write(8'h6C, 1'b0, dummy);
    check(tx_ready == 1'b0, "R9", "write during sync not taken", tx_ready, 0);
    wait_bits(fe + HL + 30);
    check_hdr(fe, 8'h12, "R9");
    expect_ones(fe + HL, 30, "R9");
  endtask

  task automatic t_queue;
    int fe, dummy, guard;
    do_write(8'h21, 1'b1, fe);
    guard = 0;
    while (tx_ready != 1'b1 && guard < 20000) begin
      @(posedge clk); #1;
      guard++;
    end
    do_write(8'h34, 1'b1, dummy);
    check(tx_ready == 1'b0, "R10", "write during identifier taken", tx_ready, 0);
    wait_bits(fe + 2 * HL + 6);
    check_hdr(fe, prot(8'h21), "R7");
    check(bits[fe + HL] == 1'b0 && bits[fe + HL - 1] == 1'b1, "R10",
          "second break follows stop bit directly", bits[fe + HL], 0);
    check_hdr(fe + HL, prot(8'h34), "R10");
    expect_ones(fe + 2 * HL, 6, "R10");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_single(8'hA3, 1'b0, "R6");
    t_single(8'h00, 1'b0, "R6");
    t_single(8'hFF, 1'b0, "R6");
    t_single(8'h00, 1'b1, "R7");
    t_single(8'hFF, 1'b1, "R7");
    t_single(8'h15, 1'b1, "R7");
    t_ignore();
    t_queue();
    check(viol == 0, "R11", "txd moved between ticks", viol, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    checks++;
    errors++;
    $display("FAIL WD watchdog expired actual=%0d expected=0", 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule